// File: doc/BRIEF.md
# Two-Stage Prefetching Instruction Core

This block is a small instruction-processing core split into two stages. A fetch stage reads one instruction word per cycle from an instruction memory and holds it in a one-entry buffer. An execute stage decodes that buffered word, reads a four-entry register file, runs the adder, updates the sign and zero flags, and resolves jumps and conditional branches. Fetch of the word after the current one overlaps with execution of the current one, so straight-line code retires one instruction per clock.

When the execute stage decides that a branch is taken, the word fetched in that cycle belongs to the wrong path. The buffer is marked empty, the fetch address is loaded with the branch target, and the execute stage idles for one cycle. A conditional branch that falls through costs nothing. The instruction memory has a combinational read: the word for `imem_addr` must be on `imem_rdata` in the same cycle. A trace of each retired instruction (its address, any register write, and whether it redirected fetch) is driven to the ports.

Instruction word, 16 bits: opcode in bits 15:12. ADD=1 and SUB=2 use destination 11:10, source A 9:8 and source B 7:6. LDI=3 uses destination 11:10 and an 8-bit immediate in 7:0. JMP=4, BRP=5 and BRZ=6 carry the target in 7:0. BRE=7 compares the registers in 11:10 and 9:8 and carries the target in 7:0. Opcode 0 and opcodes 8 to 15 do nothing.

Top module: `prefetch_core`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `retire_valid` is 0, `imem_addr` is 0 and both flags are 0. The register file reads as all zeros.
- R2: While an instruction at address a executes, `imem_addr` equals a+1 (modulo the address width), so sequential code retires one instruction per cycle.
- R3: ADD (opcode 1) and SUB (opcode 2) write the sum or difference, taken modulo 2^DW, to the destination register. The write is shown on `wb_en`/`wb_idx`/`wb_data` in the cycle the instruction retires, and later instructions read the new value.
- R4: LDI (opcode 3) writes the zero-extended 8-bit immediate to the destination register and leaves the flags unchanged.
- R5: After ADD or SUB, `flag_sign` equals the result's top bit and `flag_zero` is 1 exactly when the result is zero. No other instruction changes either flag.
- R6: JMP (opcode 4) is always taken, and fetch continues at the 8-bit target.
- R7: BRP (opcode 5) is taken only when the sign flag and the zero flag are both 0.
- R8: BRZ (opcode 6) is taken only when the zero flag is 1.
- R9: BRE (opcode 7) is taken only when the two named registers hold equal values.
- R10: After a taken branch, the next cycle has `retire_valid` 0 and `imem_addr` equal to the target. The word fetched behind the branch never retires, and the target instruction retires in the cycle after that.
- R11: A conditional branch that is not taken has `retire_taken` 0, and the instruction at the next address retires in the very next cycle.
- R12: Opcode 0 and opcodes 8 to 15 retire without a register write, without a flag change and without a redirect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | PCW | Fetch address to the instruction memory |
| imem_rdata | input | 16 | Instruction word at `imem_addr`, same cycle |
| retire_valid | output | 1 | An instruction executes this cycle |
| retire_pc | output | PCW | Address of the executing instruction |
| retire_taken | output | 1 | The executing instruction redirects fetch |
| wb_en | output | 1 | Register write this cycle |
| wb_idx | output | 2 | Register written |
| wb_data | output | DW | Value written |
| flag_sign | output | 1 | Sign flag from the last ADD/SUB |
| flag_zero | output | 1 | Zero flag from the last ADD/SUB |

## Verification
A corrupted fetch address or a stale buffer shows up in the same cycle as a `retire_pc` that breaks the sequential or target order. A wrong flag or register value shows up when the next branch resolves the wrong way, or when the next write to the trace carries a wrong sum. That is often several instructions later, so the bench compares every retired cycle against its own instruction-level model rather than only checking final register contents. A failure to discard the prefetched word is seen one cycle after the branch, as a valid retire where a bubble was due.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  localparam int IW = 16;

  typedef enum logic [3:0] {
    OP_NOP = 4'd0,
    OP_ADD = 4'd1,
    OP_SUB = 4'd2,
    OP_LDI = 4'd3,
    OP_JMP = 4'd4,
    OP_BRP = 4'd5,
    OP_BRZ = 4'd6,
    OP_BRE = 4'd7
  } opcode_e;

  function automatic logic [3:0] f_op(input logic [IW-1:0] w);
    return w[15:12];
  endfunction

  function automatic logic [1:0] f_hi(input logic [IW-1:0] w);
    return w[11:10];
  endfunction

  function automatic logic [1:0] f_mid(input logic [IW-1:0] w);
    return w[9:8];
  endfunction

  function automatic logic [1:0] f_lo(input logic [IW-1:0] w);
    return w[7:6];
  endfunction

  function automatic logic [7:0] f_imm(input logic [IW-1:0] w);
    return w[7:0];
  endfunction

  // Branch decision from opcode, current flags and register equality
  function automatic logic branch_decide(input logic [3:0] op, input logic s,
                                         input logic z, input logic eq);
    case (op)
      OP_JMP:  return 1'b1;
      OP_BRP:  return !s && !z;
      OP_BRZ:  return z;
      OP_BRE:  return eq;
      default: return 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/pfc_fetch.sv
module pfc_fetch #(
  parameter int PCW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  redirect,
  input  logic [PCW-1:0]        redirect_pc,
  input  logic [pfc_pkg::IW-1:0] imem_rdata,
  output logic [PCW-1:0]        imem_addr,
  output logic                  buf_valid,
  output logic [pfc_pkg::IW-1:0] buf_word,
  output logic [PCW-1:0]        buf_pc
);
  logic [PCW-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= '0;
      buf_valid <= 1'b0;
      buf_word  <= '0;
      buf_pc    <= '0;
    end else if (redirect) begin
      pc_q      <= redirect_pc;
      buf_valid <= 1'b0;
    end else begin
      buf_word  <= imem_rdata;
      buf_pc    <= pc_q;
      buf_valid <= 1'b1;
      pc_q      <= pc_q + 1'b1;
    end
  end

  assign imem_addr = pc_q;
endmodule

// File: rtl/pfc_regfile.sv
module pfc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [$clog2(NREG)-1:0] rs1_idx,
  input  logic [$clog2(NREG)-1:0] rs2_idx,
  output logic [DW-1:0]           rs1_data,
  output logic [DW-1:0]           rs2_data,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wd_idx,
  input  logic [DW-1:0]           wd_data
);
  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (we && (wd_idx == g))
        regs[g] <= wd_data;
    end
  end

  assign rs1_data = regs[rs1_idx];
  assign rs2_data = regs[rs2_idx];
endmodule

// File: rtl/pfc_exec.sv
module pfc_exec #(
  parameter int DW  = 16,
  parameter int PCW = 8
) (
  input  logic                   valid,
  input  logic [pfc_pkg::IW-1:0] word,
  input  logic                   flag_s,
  input  logic                   flag_z,
  output logic [1:0]             rs1_idx,
  output logic [1:0]             rs2_idx,
  input  logic [DW-1:0]          rs1_data,
  input  logic [DW-1:0]          rs2_data,
  output logic                   wb_en,
  output logic [1:0]             wb_idx,
  output logic [DW-1:0]          wb_data,
  output logic                   flag_we,
  output logic                   taken,
  output logic [PCW-1:0]         target
);
  import pfc_pkg::*;

  logic [3:0]    op;
  logic [DW-1:0] sum;

  assign op = f_op(word);

  // Compare-and-branch reads the fields ahead of the ALU source fields
  always_comb begin
    if (op == OP_BRE) begin
      rs1_idx = f_hi(word);
      rs2_idx = f_mid(word);
    end else begin
      rs1_idx = f_mid(word);
      rs2_idx = f_lo(word);
    end
  end

  assign sum = (op == OP_SUB) ? rs1_data - rs2_data : rs1_data + rs2_data;

  always_comb begin
    wb_en   = 1'b0;
    flag_we = 1'b0;
    wb_idx  = f_hi(word);
    wb_data = sum;
    if (valid) begin
      case (op)
        OP_ADD, OP_SUB: begin
          wb_en   = 1'b1;
          flag_we = 1'b1;
        end
        OP_LDI: begin
          wb_en   = 1'b1;
          wb_data = DW'(f_imm(word));
        end
        default: ;
      endcase
    end
  end

  assign taken  = valid && branch_decide(op, flag_s, flag_z, rs1_data == rs2_data);
  assign target = PCW'(f_imm(word));
endmodule

// File: rtl/prefetch_core.sv
module prefetch_core #(
  parameter int DW  = 16,
  parameter int PCW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic [PCW-1:0]         imem_addr,
  input  logic [pfc_pkg::IW-1:0] imem_rdata,
  output logic                   retire_valid,
  output logic [PCW-1:0]         retire_pc,
  output logic                   retire_taken,
  output logic                   wb_en,
  output logic [1:0]             wb_idx,
  output logic [DW-1:0]          wb_data,
  output logic                   flag_sign,
  output logic                   flag_zero
);
  logic                   buf_valid;
  logic [pfc_pkg::IW-1:0] buf_word;
  logic [PCW-1:0]         buf_pc;
  logic                   redirect;
  logic [PCW-1:0]         redir_pc;
  logic [1:0]             rs1_idx, rs2_idx;
  logic [DW-1:0]          rs1_data, rs2_data;
  logic                   flag_we;

  pfc_fetch #(.PCW(PCW)) u_fetch (
    .clk(clk), .rst_n(rst_n),
    .redirect(redirect), .redirect_pc(redir_pc),
    .imem_rdata(imem_rdata), .imem_addr(imem_addr),
    .buf_valid(buf_valid), .buf_word(buf_word), .buf_pc(buf_pc)
  );

  pfc_regfile #(.DW(DW), .NREG(4)) u_rf (
    .clk(clk), .rst_n(rst_n),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rs1_data(rs1_data), .rs2_data(rs2_data),
    .we(wb_en), .wd_idx(wb_idx), .wd_data(wb_data)
  );

  pfc_exec #(.DW(DW), .PCW(PCW)) u_exec (
    .valid(buf_valid), .word(buf_word),
    .flag_s(flag_sign), .flag_z(flag_zero),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
    .rs1_data(rs1_data), .rs2_data(rs2_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .flag_we(flag_we), .taken(redirect), .target(redir_pc)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_sign <= 1'b0;
      flag_zero <= 1'b0;
    end else if (flag_we) begin
      flag_sign <= wb_data[DW-1];
      flag_zero <= (wb_data == '0);
    end
  end

  assign retire_valid = buf_valid;
  assign retire_pc    = buf_pc;
  assign retire_taken = redirect;
endmodule

// File: rtl/pfc_checker.sv
module pfc_checker #(
  parameter int DW  = 16,
  parameter int PCW = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [PCW-1:0] imem_addr,
  input logic           retire_valid,
  input logic [PCW-1:0] retire_pc,
  input logic           retire_taken,
  input logic           wb_en,
  input logic [DW-1:0]  wb_data,
  input logic           flag_sign,
  input logic           flag_zero,
  input logic           alu_upd,
  input logic [PCW-1:0] redirect_pc
);
  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!retire_valid && imem_addr == '0));

  p_prefetch_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retire_valid |-> (imem_addr == PCW'(retire_pc + 1'b1)));

  p_write_retires_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> retire_valid);

  p_flags_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !alu_upd |=> $stable({flag_sign, flag_zero}));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    alu_upd |=> (flag_zero == ($past(wb_data) == '0)));

  p_target_fetch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_taken) |=> (imem_addr == $past(redirect_pc)));

  p_bubble_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && retire_taken) |=> !retire_valid);

  p_fallthrough_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_valid && !retire_taken) |=>
      (retire_valid && retire_pc == PCW'($past(retire_pc) + 1'b1)));
endmodule

bind prefetch_core pfc_checker #(.DW(DW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr),
  .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_taken(retire_taken),
  .wb_en(wb_en), .wb_data(wb_data), .flag_sign(flag_sign), .flag_zero(flag_zero),
  .alu_upd(flag_we), .redirect_pc(redir_pc)
);

// File: tb/tb_prefetch_core.sv
`timescale 1ns/1ps
module tb_prefetch_core;
  localparam int DW  = 16;
  localparam int PCW = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [PCW-1:0] imem_addr;
  logic [15:0]    imem_rdata;
  logic           retire_valid, retire_taken, wb_en, flag_sign, flag_zero;
  logic [PCW-1:0] retire_pc;
  logic [1:0]     wb_idx;
  logic [DW-1:0]  wb_data;

  logic [15:0] mem [256];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  // model state
  logic [PCW-1:0] m_pc;
  logic [DW-1:0]  m_r [4];
  logic           m_s, m_z, m_bubble;

  always #2 clk = ~clk;
  assign imem_rdata = mem[imem_addr];

  prefetch_core #(.DW(DW), .PCW(PCW)) dut (
    .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
    .retire_valid(retire_valid), .retire_pc(retire_pc), .retire_taken(retire_taken),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .flag_sign(flag_sign), .flag_zero(flag_zero)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] enc(input int op, input int a, input int b, input int c);
    return {op[3:0], a[1:0], b[1:0], c[1:0], 6'd0};
  endfunction

  function automatic logic [15:0] enci(input int op, input int a, input int b, input int imm);
    return {op[3:0], a[1:0], b[1:0], imm[7:0]};
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd1, 4'd2: return "R3";
      4'd3:       return "R4";
      4'd4:       return "R6";
      4'd5:       return "R7";
      4'd6:       return "R8";
      4'd7:       return "R9";
      default:    return "R12";
    endcase
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!retire_valid, "R1", "retire_valid in reset", 32'(retire_valid), 0);
    rst_n = 1'b1;
    #0.5;
    chk(!retire_valid && imem_addr == 0, "R1", "idle after release",
        {retire_valid, 8'(imem_addr)}, 0);
    chk(!flag_sign && !flag_zero, "R1", "flags after reset",
        {flag_sign, flag_zero}, 0);
    m_pc = '0;
    m_s = 0; m_z = 0;
    m_bubble = 1'b0;
    for (int i = 0; i < 4; i++) m_r[i] = '0;
  endtask

  task automatic run(input int cycles);
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      chk(flag_sign == m_s && flag_zero == m_z, "R5", "flags",
          {flag_sign, flag_zero}, {m_s, m_z});
      if (m_bubble) begin
        chk(!retire_valid, "R10", "bubble after taken branch", 32'(retire_valid), 0);
        chk(imem_addr == m_pc, "R10", "fetch at target", 32'(imem_addr), 32'(m_pc));
        m_bubble = 1'b0;
      end else begin : exec_one
        logic [15:0] w;
        logic [3:0] op;
        logic [DW-1:0] a, b, res;
        bit e_wen, e_tk, e_alu;
        logic [1:0] e_idx;
        string t;
        w = mem[m_pc];
        op = w[15:12];
        t = tag_of(op);
        e_wen = 0; e_tk = 0; e_alu = 0; e_idx = w[11:10]; res = '0;
        chk(retire_valid && retire_pc == m_pc, "R2", "retired address",
            {retire_valid, 8'(retire_pc)}, {1'b1, 8'(m_pc)});
        chk(imem_addr == PCW'(m_pc + 1), "R2", "prefetch address",
            32'(imem_addr), 32'(PCW'(m_pc + 1)));
        case (op)
          4'd1, 4'd2: begin
            a = m_r[w[9:8]]; b = m_r[w[7:6]];
            res = (op == 4'd1) ? a + b : a - b;
            e_wen = 1; e_alu = 1;
          end
          4'd3: begin res = DW'(w[7:0]); e_wen = 1; end
          4'd4: e_tk = 1;
          4'd5: e_tk = !m_s && !m_z;
          4'd6: e_tk = m_z;
          4'd7: e_tk = (m_r[w[11:10]] == m_r[w[9:8]]);
          default: ;
        endcase
        if (op >= 4'd5 && op <= 4'd7 && !e_tk) t = "R11";
        chk(wb_en == e_wen, t, "write enable", 32'(wb_en), 32'(e_wen));
        if (e_wen)
          chk(wb_idx == e_idx && wb_data == res, t, "write idx/data",
              {wb_idx, wb_data}, {e_idx, res});
        chk(retire_taken == e_tk, t, "branch decision", 32'(retire_taken), 32'(e_tk));
        if (e_wen) m_r[e_idx] = res;
        if (e_alu) begin m_s = res[DW-1]; m_z = (res == '0); end
        if (e_tk) begin m_pc = w[7:0]; m_bubble = 1'b1; end
        else m_pc = PCW'(m_pc + 1);
      end
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    // directed program
    mem[0]  = enci(3, 0, 0, 5);      // LDI r0,5
    mem[1]  = enci(3, 1, 0, 5);      // LDI r1,5
    mem[2]  = enc(2, 2, 0, 1);       // SUB r2=r0-r1 -> zero
    mem[3]  = enci(6, 0, 0, 10);     // BRZ 10 taken
    mem[4]  = enci(3, 3, 0, 8'hFF);  // wrong path, must not retire
    mem[10] = enci(5, 0, 0, 40);     // BRP not taken (zero)
    mem[11] = enc(1, 2, 0, 1);       // ADD r2=10
    mem[12] = enci(5, 0, 0, 16);     // BRP taken
    mem[13] = enci(3, 3, 0, 8'hEE);  // wrong path
    mem[16] = enci(7, 0, 1, 20);     // BRE r0,r1 taken
    mem[20] = enci(3, 3, 0, 1);      // LDI r3,1 (flags kept)
    mem[21] = enci(7, 0, 3, 40);     // BRE not taken
    mem[22] = enc(2, 2, 3, 0);       // SUB r2=1-5 negative
    mem[23] = enci(5, 0, 0, 40);     // BRP not taken (sign)
    mem[24] = enci(6, 0, 0, 40);     // BRZ not taken
    mem[25] = 16'h0000;              // NOP
    mem[26] = 16'hF3C5;              // unused opcode
    mem[27] = enc(1, 0, 0, 0);       // ADD r0=r0+r0
    mem[28] = enci(4, 0, 0, 0);      // JMP 0
    do_reset();
    run(80);
    // random programs with a fixed seed
    void'($urandom(32'h5A17));
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 256; i++) begin
        int k;
        k = $urandom % 16;
        if (k < 4)       mem[i] = enc(1, $urandom, $urandom, $urandom);
        else if (k < 7)  mem[i] = enc(2, $urandom, $urandom, $urandom);
        else if (k < 9)  mem[i] = enci(3, $urandom, 0, $urandom);
        else if (k == 9) mem[i] = enci(4, 0, 0, $urandom);
        else if (k == 10) mem[i] = enci(5, 0, 0, $urandom);
        else if (k == 11) mem[i] = enci(6, 0, 0, $urandom);
        else if (k == 12) mem[i] = enci(7, $urandom, $urandom, $urandom);
        else if (k == 13) mem[i] = 16'($urandom) | 16'h8000;
        else             mem[i] = 16'h0000;
      end
      do_reset();
      run(2000);
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule